// File: doc/BRIEF.md
# Latched-Address One-Time-Programmable Memory

This block is a synthesizable model of a 2048-word by 8-bit fuse memory. Reads use a strobed interface. The system clock samples an active-low chip enable and an active-low output enable. When the chip enable is seen going from high to low, the block captures the address in an internal latch. After a fixed access delay it presents the addressed word. A separate output enable controls the pad drivers. The data outputs are high-impedance whenever either enable is high. The block does not drive tri-state nets itself. It provides the data and a drive-enable flag, and the chip's pad ring builds the three-state buffer from them.

Storage is one-time programmable. Every fuse starts at 0. After reset, a clearing sweep writes zero to every row, and the block reports that it is busy while the sweep runs. A programming request is a one-cycle strobe that carries an address and a one-hot bit mask. The request is honoured only while the program control is low and the output enable is high. The addressed bit then becomes 1, and no request can ever return a bit to 0.

The array has 128 rows of 128 fuses each and sits in a single inferable RAM. Each row holds 16 columns for each of the 8 data bits. Programming is a read-modify-write of one row.

Top module: `otp_latched_mem`

## Requirements
- R1: While reset is high and for a 128-cycle clearing sweep after it, `init_busy` is 1 and `rd_valid` is 0. After the sweep, every one of the 2048 words reads 0x00.
- R2: The block captures the address on the clock edge that first samples `chip_en_n` low after it was sampled high. Address changes after that edge do not change the word presented during the access.
- R3: `rd_valid` is 0 while `chip_en_n` is high. It becomes 1 exactly ACCESS_LAT (default 3) clock edges after the capturing edge. From then on, `rd_data` holds the stored word of the latched address.
- R4: `pad_drive` becomes 1 one edge after an edge that samples both `chip_en_n` and `out_en_n` low. It becomes 0 one edge after an edge that samples either of them high. While `pad_drive` is 0, the pads are high-impedance.
- R5: A programming request is accepted when all of these hold on the same edge: `prog_stb` is 1, `prog_en_n` is 0, `out_en_n` is 1, the engine is idle and `init_busy` is 0. If `prog_mask` has exactly one bit set, that bit of the word at `addr` becomes 1. The fuse for data bit b of a word sits in row addr[10:4], column b*16+addr[3:0].
- R6: A fuse that holds 1 is never cleared. Programming one bit leaves the other bits of that word and all other words unchanged. Programming a bit that is already 1 keeps it at 1.
- R7: An accepted-condition request whose `prog_mask` has zero bits or more than one bit set raises `prog_err` for exactly one cycle, one edge later. It changes no fuse.
- R8: A request made while `prog_en_n` is 1 or `out_en_n` is 0 is ignored. It raises no `prog_err` and changes no fuse.
- R9: An accepted request occupies the engine for the two edges that follow it. Strobes on those edges are ignored and raise no `prog_err`.
- R10: After a programming request completes, a later read of that word returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all strobes |
| rst | input | 1 | Synchronous active-high reset |
| chip_en_n | input | 1 | Active-low chip enable; its falling edge captures the address |
| out_en_n | input | 1 | Active-low output enable |
| addr | input | 11 | Word address for reads and programming |
| prog_en_n | input | 1 | Active-low program control |
| prog_stb | input | 1 | One-cycle programming request strobe |
| prog_mask | input | 8 | Bit to program, one-hot |
| rd_data | output | 8 | Word of the latched address |
| rd_valid | output | 1 | Access delay has elapsed; rd_data is meaningful |
| pad_drive | output | 1 | Enable for the chip's three-state data pads |
| prog_err | output | 1 | One-cycle pulse on a rejected multi-bit or empty mask |
| init_busy | output | 1 | Clearing sweep in progress |

## Verification
Results arrive at fixed delays. Call the edge that samples the chip enable low after high edge k. Then `rd_valid` must still be 0 after edges k through k+ACCESS_LAT-1, and it must be 1, with the expected word on `rd_data`, after edge k+ACCESS_LAT. `pad_drive` and `prog_err` follow one edge after their sampled causes. A programmed bit is checked by a read started at least three edges after the strobe. The bench drives inputs and samples outputs at falling clock edges. It counts edges from the capturing edge before each comparison, and it compares against a byte-per-word model that only sets bits.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    PG_IDLE  = 2'd0,
    PG_READ  = 2'd1,
    PG_WRITE = 2'd2
  } prog_state_e;
endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int ROW_BITS = 7,
  parameter int ROW_W    = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ROW_BITS-1:0] rd_row,
  output logic [ROW_W-1:0]    rd_row_data,
  input  logic                wr_en,
  input  logic [ROW_BITS-1:0] wr_row,
  input  logic [ROW_W-1:0]    wr_row_data,
  output logic                init_busy
);
  localparam int ROWS = 1 << ROW_BITS;

  logic [ROW_W-1:0]    mem [ROWS];
  logic [ROW_BITS-1:0] clr_row;
  logic                busy_q;
  logic                mem_we;
  logic [ROW_BITS-1:0] mem_wa;
  logic [ROW_W-1:0]    mem_wd;

  // clearing sweep: one row per cycle after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b1;
      clr_row <= '0;
    end else if (busy_q) begin
      clr_row <= clr_row + 1'b1;
      if (clr_row == ROW_BITS'(ROWS - 1)) busy_q <= 1'b0;
    end
  end

  assign init_busy = busy_q;
  assign mem_we    = (busy_q && !rst) || wr_en;
  assign mem_wa    = busy_q ? clr_row : wr_row;
  assign mem_wd    = busy_q ? '0 : wr_row_data;

  // simple dual-port, read-first: block RAM friendly
  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
    rd_row_data <= mem[rd_row];
  end
endmodule

// File: rtl/otp_access_ctrl.sv
module otp_access_ctrl #(
  parameter int ADDR_W     = 11,
  parameter int ACCESS_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              init_busy,
  output logic [ADDR_W-1:0] addr_lat,
  output logic              access_on,
  output logic              rd_valid,
  output logic              pad_drive
);
  localparam int LAT_W = $clog2(ACCESS_LAT + 1);

  logic             ce_q;
  logic [LAT_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q      <= 1'b1;
      access_on <= 1'b0;
      wait_cnt  <= '0;
      addr_lat  <= '0;
      pad_drive <= 1'b0;
    end else begin
      ce_q      <= chip_en_n;
      pad_drive <= !chip_en_n && !out_en_n;
      if (chip_en_n) begin
        access_on <= 1'b0;
      end else if (ce_q) begin
        access_on <= 1'b1;
        addr_lat  <= addr;
        wait_cnt  <= LAT_W'(ACCESS_LAT);
      end else if (wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
      end
    end
  end

  assign rd_valid = access_on && (wait_cnt == '0) && !init_busy;

  // R2: latch holds for the whole access
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (rst)
    (access_on && !chip_en_n) |=> $stable(addr_lat));
  // R4: pads only driven inside an access
  a_r4_drive_in_access: assert property (@(posedge clk) disable iff (rst)
    pad_drive |-> access_on);
  // R3: a fresh access is never valid at once
  a_r3_no_early_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(access_on) |-> !rd_valid);
endmodule

// File: rtl/otp_prog_engine.sv
module otp_prog_engine
  import otp_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int WORD_W   = 8,
  parameter int COL_BITS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       prog_stb,
  input  logic                       prog_en_n,
  input  logic                       out_en_n,
  input  logic                       init_busy,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [WORD_W-1:0]          prog_mask,
  input  logic [WORD_W*(1<<COL_BITS)-1:0] rd_row_data,
  output logic                       pg_rd_req,
  output logic [ADDR_W-COL_BITS-1:0] pg_row,
  output logic                       wr_en,
  output logic [WORD_W*(1<<COL_BITS)-1:0] wr_row_data,
  output logic                       prog_err
);
  localparam int COLS     = 1 << COL_BITS;
  localparam int ROW_BITS = ADDR_W - COL_BITS;
  localparam int ROW_W    = WORD_W * COLS;

  prog_state_e         st;
  logic [ROW_BITS-1:0] row_r;
  logic [COL_BITS-1:0] col_r;
  logic [WORD_W-1:0]   mask_r;
  logic [ROW_W-1:0]    set_vec;
  logic                try_req;
  logic                one_bit;

  assign try_req = prog_stb && !prog_en_n && out_en_n && !init_busy && (st == PG_IDLE);
  assign one_bit = ($countones(prog_mask) == 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PG_IDLE;
      prog_err <= 1'b0;
      row_r    <= '0;
      col_r    <= '0;
      mask_r   <= '0;
    end else begin
      prog_err <= 1'b0;
      unique case (st)
        PG_IDLE: if (try_req) begin
          if (one_bit) begin
            row_r  <= addr[ADDR_W-1:COL_BITS];
            col_r  <= addr[COL_BITS-1:0];
            mask_r <= prog_mask;
            st     <= PG_READ;
          end else begin
            prog_err <= 1'b1;
          end
        end
        PG_READ:  st <= PG_WRITE;
        PG_WRITE: st <= PG_IDLE;
        default:  st <= PG_IDLE;
      endcase
    end
  end

  // data bit b of a word lives at column b*COLS + col
  always_comb begin
    set_vec = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (mask_r[b]) set_vec[b*COLS + int'(col_r)] = 1'b1;
    end
  end

  assign pg_rd_req   = (st == PG_READ);
  assign pg_row      = row_r;
  assign wr_en       = (st == PG_WRITE);
  assign wr_row_data = rd_row_data | set_vec;

  // R7: bad mask is flagged and starts no write
  a_r7_reject_no_write: assert property (@(posedge clk) disable iff (rst)
    (try_req && !one_bit) |=> (prog_err && st == PG_IDLE));
  // R5: each write sets exactly one fuse
  a_r5_single_fuse: assert property (@(posedge clk) disable iff (rst)
    (st == PG_WRITE) |-> ($countones(set_vec) == 1));
  // R9: strobes during an operation raise no error
  a_r9_busy_no_err: assert property (@(posedge clk) disable iff (rst)
    (st != PG_IDLE) |=> !prog_err);
  // R1: no programming during the clearing sweep
  a_r1_idle_in_init: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> (st == PG_IDLE));
endmodule

// File: rtl/otp_latched_mem.sv
module otp_latched_mem #(
  parameter int ADDR_W     = 11,
  parameter int WORD_W     = 8,
  parameter int COL_BITS   = 4,
  parameter int ACCESS_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              prog_en_n,
  input  logic              prog_stb,
  input  logic [WORD_W-1:0] prog_mask,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              pad_drive,
  output logic              prog_err,
  output logic              init_busy
);
  localparam int ROW_BITS = ADDR_W - COL_BITS;
  localparam int COLS     = 1 << COL_BITS;
  localparam int ROW_W    = WORD_W * COLS;

  logic [ADDR_W-1:0]   addr_lat;
  logic                access_on;
  logic                pg_rd_req;
  logic [ROW_BITS-1:0] pg_row;
  logic                wr_en;
  logic [ROW_W-1:0]    wr_row_data;
  logic [ROW_W-1:0]    rd_row_data;
  logic [ROW_BITS-1:0] rd_row;
  logic                rd_for_access;
  logic [COL_BITS-1:0] col_d;
  logic [WORD_W-1:0]   word_sel;

  otp_access_ctrl #(.ADDR_W(ADDR_W), .ACCESS_LAT(ACCESS_LAT)) u_ctrl (
    .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
    .addr(addr), .init_busy(init_busy), .addr_lat(addr_lat),
    .access_on(access_on), .rd_valid(rd_valid), .pad_drive(pad_drive)
  );

  otp_prog_engine #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .COL_BITS(COL_BITS)) u_prog (
    .clk(clk), .rst(rst), .prog_stb(prog_stb), .prog_en_n(prog_en_n),
    .out_en_n(out_en_n), .init_busy(init_busy), .addr(addr),
    .prog_mask(prog_mask), .rd_row_data(rd_row_data), .pg_rd_req(pg_rd_req),
    .pg_row(pg_row), .wr_en(wr_en), .wr_row_data(wr_row_data),
    .prog_err(prog_err)
  );

  assign rd_row = pg_rd_req ? pg_row : addr_lat[ADDR_W-1:COL_BITS];

  otp_fuse_array #(.ROW_BITS(ROW_BITS), .ROW_W(ROW_W)) u_array (
    .clk(clk), .rst(rst), .rd_row(rd_row), .rd_row_data(rd_row_data),
    .wr_en(wr_en), .wr_row(pg_row), .wr_row_data(wr_row_data),
    .init_busy(init_busy)
  );

  // column decode: one fuse per data bit out of its 16-column group
  for (genvar b = 0; b < WORD_W; b++) begin : g_col
    assign word_sel[b] = rd_row_data[b*COLS + int'(col_d)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_for_access <= 1'b0;
      col_d         <= '0;
      rd_data       <= '0;
    end else begin
      rd_for_access <= !pg_rd_req;
      col_d         <= addr_lat[COL_BITS-1:0];
      if (rd_for_access) rd_data <= word_sel;
    end
  end

  initial begin
    if (ACCESS_LAT < 2) $error("ACCESS_LAT must cover the two-stage read path");
  end
endmodule

// File: tb/tb_otp_latched_mem.sv
module tb_otp_latched_mem;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int NWORDS     = 2048;
  localparam int NROWS      = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chip_en_n = 1'b1;
  logic        out_en_n = 1'b0;
  logic [10:0] addr = '0;
  logic        prog_en_n = 1'b1;
  logic        prog_stb = 1'b0;
  logic [7:0]  prog_mask = '0;
  logic [7:0]  rd_data;
  logic        rd_valid, pad_drive, prog_err, init_busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] model [NWORDS];
  logic [10:0] pool [8];

  otp_latched_mem #(.ACCESS_LAT(LAT)) dut (
    .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
    .addr(addr), .prog_en_n(prog_en_n), .prog_stb(prog_stb),
    .prog_mask(prog_mask), .rd_data(rd_data), .rd_valid(rd_valid),
    .pad_drive(pad_drive), .prog_err(prog_err), .init_busy(init_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit mask_ok(input logic [7:0] m);
    return $countones(m) == 1;
  endfunction

  function automatic bit req_taken(input bit pn, input bit gn);
    return (pn == 1'b0) && (gn == 1'b1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // read word a; address is scrambled after capture (R2)
  task automatic do_read(input logic [10:0] a);
    @(negedge clk);
    chip_en_n = 1'b1;
    addr = 11'($urandom);
    @(negedge clk);
    chk(!rd_valid, "R3 valid low while E high", int'(rd_valid), 0);
    addr = a;
    chip_en_n = 1'b0;
    @(negedge clk);                       // after capturing edge k
    addr = ~a;                            // R2: must not disturb access
    chk(!rd_valid, "R3 not valid at capture", int'(rd_valid), 0);
    repeat (LAT - 1) @(negedge clk);      // after edge k+LAT-1
    chk(!rd_valid, "R3 not valid before latency", int'(rd_valid), 0);
    @(negedge clk);                       // after edge k+LAT
    chk(rd_valid, "R3 valid at latency", int'(rd_valid), 1);
    chk(rd_data == model[a], "R2/R10 read data", int'(rd_data), int'(model[a]));
    chk(pad_drive == !out_en_n, "R4 drive during access", int'(pad_drive), int'(!out_en_n));
  endtask

  task automatic do_prog(input logic [10:0] a, input logic [7:0] m, input bit pn, input bit gn);
    bit exp_err;
    @(negedge clk);
    chip_en_n = 1'b1;
    out_en_n = gn;
    prog_en_n = pn;
    addr = a;
    prog_mask = m;
    prog_stb = 1'b1;
    @(negedge clk);
    prog_stb = 1'b0;
    prog_en_n = 1'b1;
    exp_err = req_taken(pn, gn) && !mask_ok(m);
    chk(prog_err == exp_err, exp_err ? "R7 error pulse" : "R8 no error", int'(prog_err), int'(exp_err));
    if (req_taken(pn, gn) && mask_ok(m)) model[a] = model[a] | m;   // R5/R6
    @(negedge clk);
    chk(!prog_err, "R7 error single cycle", int'(prog_err), 0);
    repeat (2) @(negedge clk);
    out_en_n = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int busy_cycles;
    void'($urandom(32'd4711));
    for (int i = 0; i < NWORDS; i++) model[i] = 8'h00;
    for (int i = 0; i < 8; i++) pool[i] = 11'($urandom);
    pool[0] = 11'h000;
    pool[1] = 11'h7ff;
    pool[2] = 11'h00f;   // last column of row 0
    pool[3] = 11'h010;   // first column of row 1

    // R1: reset and sweep
    repeat (3) @(negedge clk);
    chk(init_busy, "R1 busy in reset", int'(init_busy), 1);
    chk(!rd_valid, "R1 no valid in reset", int'(rd_valid), 0);
    chk(!pad_drive, "R4 no drive in reset", int'(pad_drive), 0);
    rst = 1'b0;
    busy_cycles = 0;
    while (init_busy && busy_cycles < 1000) begin
      @(negedge clk);
      busy_cycles++;
    end
    chk(busy_cycles == NROWS, "R1 sweep length", busy_cycles, NROWS);

    do_read(11'h000);
    do_read(11'h7ff);
    do_read(11'h3a5);

    // R4: output enable gating inside an access
    @(negedge clk);
    out_en_n = 1'b1;
    @(negedge clk);
    chk(!pad_drive, "R4 G high -> hi-Z", int'(pad_drive), 0);
    out_en_n = 1'b0;
    @(negedge clk);
    chk(pad_drive, "R4 G low -> drive", int'(pad_drive), 1);
    chip_en_n = 1'b1;
    @(negedge clk);
    chk(!pad_drive, "R4 E high -> hi-Z", int'(pad_drive), 0);
    chk(!rd_valid, "R3 E high drops valid", int'(rd_valid), 0);

    // R5/R10: directed programming, neighbour columns across rows
    do_prog(11'h00f, 8'h80, 1'b0, 1'b1);
    do_prog(11'h010, 8'h01, 1'b0, 1'b1);
    do_read(11'h00f);
    do_read(11'h010);
    do_read(11'h00e);                     // R6: neighbour untouched
    // R6: reprogramming a set bit keeps it
    do_prog(11'h00f, 8'h80, 1'b0, 1'b1);
    do_read(11'h00f);
    // R7: empty and multi-bit masks
    do_prog(11'h123, 8'h00, 1'b0, 1'b1);
    do_prog(11'h123, 8'h11, 1'b0, 1'b1);
    do_read(11'h123);
    // R8: P high, then G low
    do_prog(11'h124, 8'h04, 1'b1, 1'b1);
    do_prog(11'h124, 8'h04, 1'b0, 1'b0);
    do_read(11'h124);

    // R9: second strobe during the operation is ignored
    @(negedge clk);
    chip_en_n = 1'b1;
    out_en_n = 1'b1;
    prog_en_n = 1'b0;
    addr = 11'h200;
    prog_mask = 8'h01;
    prog_stb = 1'b1;
    @(negedge clk);
    prog_mask = 8'h06;                    // would be an error if seen
    @(negedge clk);
    prog_mask = 8'h02;
    @(negedge clk);
    prog_stb = 1'b0;
    prog_en_n = 1'b1;
    chk(!prog_err, "R9 busy strobe ignored", int'(prog_err), 0);
    model[11'h200] = 8'h01;
    repeat (3) @(negedge clk);
    out_en_n = 1'b0;
    do_read(11'h200);

    // random mix
    for (int it = 0; it < 120; it++) begin
      logic [10:0] a;
      logic [7:0]  m;
      bit pn, gn;
      a  = pool[$urandom_range(0, 7)];
      m  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : (8'h01 << $urandom_range(0, 7));
      pn = ($urandom_range(0, 3) == 0);
      gn = ($urandom_range(0, 3) != 0);
      do_prog(a, m, pn, gn);
      do_read(pool[$urandom_range(0, 7)]);
    end
    for (int i = 0; i < 8; i++) do_read(pool[i]);   // R6: nothing cleared

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule